// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarms

This block is a real-time-clock peripheral that sits on a simple single-cycle 32-bit register bus. It counts seconds on a pulse input that is one clock wide and arrives once per second. Two counters run side by side. One counts up. The other counts down, and software keeps it at the all-ones complement of the up-counter. Two 32-bit comparators watch the up-counter. When an enabled comparator matches, it latches a status bit. The latched status bits drive an interrupt line and a power-on-switch line.

Software uses the block as follows. It sets the halt bit in the control register. It writes both counters, then clears the halt bit, so no tick can land between the two counter writes. An alarm is armed by writing a compare value and setting that comparator's enable bit. A key register keeps its value through the block's software reset, so start-up code can tell whether first-time setup has already been done. A 32-word scratch window gives software a small amount of general storage.

Top module: `sec_rtc`

## Requirements
- R1: After reset the registers read as follows: up-counter 0, down-counter 0xFFFFFFFF, both compare registers 0xFFFFFFFF, control 0, status 0, key 0. The irq_o and pwr_on_o outputs are low.
- R2: Registers sit at these byte offsets: up-counter 0x00, down-counter 0x04, compare0 0x08, compare1 0x0C, control 0x10, status 0x14, key 0x18. A read of any other offset below 0x80 returns 0. Control bit 5 always reads 0.
- R3: A tick pulse, while counting is allowed, adds 1 to the up-counter and subtracts 1 from the down-counter. Both wrap modulo 2^32.
- R4: While control bit 6 (halt) is set, tick pulses leave both counters unchanged.
- R5: A bus write to a counter in the same cycle as a tick stores the written value, not the incremented or decremented value.
- R6: When compare n is enabled (control bit 0 for compare0, bit 1 for compare1) and the up-counter equals compare n, status bit n is set on the next clock. It is set again on every cycle the equality holds, including right after a clear. With the enable bit clear, equality sets nothing.
- R7: Writing a 1 to a status bit at 0x14 clears it. Writing a 0 leaves that bit unchanged.
- R8: irq_o is high exactly when (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R9: Status bit 2 is set when an enabled compare hit is routed to the power-on switch (control bit 2 routes compare0, bit 3 routes compare1). pwr_on_o is high when control bit 7 is set, or (status bit 0 AND control bit 2), or (status bit 1 AND control bit 3).
- R10: While control bit 4 (soft reset) is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF. Control, compare and key registers, and scratch contents, keep their values.
- R11: Byte offsets 0x80 to 0xFC form 32 read/write scratch words, one per word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle; 0 when no read is in progress |
| irq_o | output | 1 | Alarm interrupt |
| pwr_on_o | output | 1 | Power-on-switch request |

## Verification
The hardest case to reach is a status clear that lands while a compare is still holding. The status bit must survive that write. This can only happen while the up-counter sits on the compare value, so the stimulus parks the counter there with the halt bit set. It then clears the status and reads it back. It then moves the compare value away and clears again, to show that the clear takes effect once the equality is gone. Counter wrap is reached by loading a value just below 2^32 while halted and sweeping ticks across the wrap point. The 32 scratch words are swept in full.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // Register byte offsets. Software depends on these positions.
  localparam int unsigned OFF_UP    = 32'h00;
  localparam int unsigned OFF_DN    = 32'h04;
  localparam int unsigned OFF_CMP0  = 32'h08;
  localparam int unsigned OFF_CTRL  = 32'h10;
  localparam int unsigned OFF_STAT  = 32'h14;
  localparam int unsigned OFF_KEY   = 32'h18;
  localparam int unsigned OFF_SCR   = 32'h80;

  localparam int unsigned NUM_CMP   = 2;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned STAT_W    = 3;

  // Control bit positions
  localparam int unsigned CB_CMP_EN0  = 0;
  localparam int unsigned CB_PWR_RT0  = 2;
  localparam int unsigned CB_SWRST    = 4;
  localparam int unsigned CB_HALT     = 6;
  localparam int unsigned CB_PWR_FRC  = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

  // Status bit positions
  localparam int unsigned SB_PWR = 2;
endpackage

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic          clr,
  input  logic          up_we,
  input  logic          dn_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] up_q,
  output logic [DW-1:0] dn_q
);
  logic [DW-1:0] up_d, dn_d;
  logic          adv;

  assign adv = tick & ~halt;

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (clr) begin
      up_d = '0;
      dn_d = '1;
    end else begin
      if (up_we)    up_d = wdata;
      else if (adv) up_d = up_q + DW'(1);
      if (dn_we)    dn_d = wdata;
      else if (adv) dn_d = dn_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '1;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end
endmodule

// File: rtl/sec_rtc_match.sv
module sec_rtc_match #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          en,
  input  logic [DW-1:0] cnt,
  output logic [DW-1:0] cmp_q,
  output logic          hit
);
  logic [DW-1:0] cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (we) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '1;
    else        cmp_q <= cmp_d;
  end

  assign hit = en & (cnt == cmp_q);
endmodule

// File: rtl/sec_rtc_scratch.sv
module sec_rtc_scratch #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic wen;
    assign wen = we & (widx == IW'(w));
    always_ff @(posedge clk) begin
      if (wen) mem[w] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SRAM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              pwr_on_o
);
  localparam int unsigned IW       = $clog2(SRAM_WORDS);
  localparam int unsigned SCR_END  = OFF_SCR + 4 * SRAM_WORDS;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // Decode
  logic wr, rd;
  logic sel_up, sel_dn, sel_ctrl, sel_stat, sel_key, sel_scr;
  logic [NUM_CMP-1:0] sel_cmp;
  logic [ADDR_W:0]    addr_x;

  assign wr       = bus_valid_i &  bus_write_i;
  assign rd       = bus_valid_i & ~bus_write_i;
  assign addr_x   = {1'b0, bus_addr_i};
  assign sel_up   = bus_addr_i == ADDR_W'(OFF_UP);
  assign sel_dn   = bus_addr_i == ADDR_W'(OFF_DN);
  assign sel_ctrl = bus_addr_i == ADDR_W'(OFF_CTRL);
  assign sel_stat = bus_addr_i == ADDR_W'(OFF_STAT);
  assign sel_key  = bus_addr_i == ADDR_W'(OFF_KEY);
  assign sel_scr  = (addr_x >= (ADDR_W+1)'(OFF_SCR)) &&
                    (addr_x <  (ADDR_W+1)'(SCR_END)) &&
                    (bus_addr_i[1:0] == 2'b00);

  // Control, status, key registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [STAT_W-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic [DW-1:0]     key_q, key_d;
  logic              key_we, up_we, dn_we;
  logic [NUM_CMP-1:0] hit;

  assign key_we = wr & sel_key;
  assign up_we  = wr & sel_up;
  assign dn_we  = wr & sel_dn;

  assign stat_set[NUM_CMP-1:0] = hit;
  assign stat_set[SB_PWR]      = |(hit & ctrl_q[CB_PWR_RT0 +: NUM_CMP]);
  assign stat_clr              = (wr & sel_stat) ? bus_wdata_i[STAT_W-1:0] : '0;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && sel_ctrl) ctrl_d = bus_wdata_i[CTRL_W-1:0] & CTRL_MASK;
    stat_d = (stat_q & ~stat_clr) | stat_set;
    key_d  = key_q;
    if (key_we) key_d = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      key_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      key_q  <= key_d;
    end
  end

  // Counters
  logic [DW-1:0] up_cnt, dn_cnt;
  sec_rtc_counter #(.DW(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick_i),
    .halt  (ctrl_q[CB_HALT]),
    .clr   (ctrl_q[CB_SWRST]),
    .up_we (up_we),
    .dn_we (dn_we),
    .wdata (bus_wdata_i),
    .up_q  (up_cnt),
    .dn_q  (dn_cnt)
  );

  // Comparators
  logic [DW-1:0] cmp_val [NUM_CMP];
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign sel_cmp[i] = bus_addr_i == ADDR_W'(OFF_CMP0 + 4 * i);
    sec_rtc_match #(.DW(DW)) u_match (
      .clk   (clk),
      .rst_n (rst_int_n),
      .we    (wr & sel_cmp[i]),
      .wdata (bus_wdata_i),
      .en    (ctrl_q[CB_CMP_EN0 + i]),
      .cnt   (up_cnt),
      .cmp_q (cmp_val[i]),
      .hit   (hit[i])
    );
  end

  // Scratch words
  logic [DW-1:0] scr_rdata;
  sec_rtc_scratch #(.DW(DW), .WORDS(SRAM_WORDS)) u_scr (
    .clk   (clk),
    .we    (wr & sel_scr),
    .widx  (bus_addr_i[IW+1:2]),
    .wdata (bus_wdata_i),
    .ridx  (bus_addr_i[IW+1:2]),
    .rdata (scr_rdata)
  );

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (sel_up)        bus_rdata_o = up_cnt;
      else if (sel_dn)   bus_rdata_o = dn_cnt;
      else if (sel_ctrl) bus_rdata_o = DW'(ctrl_q);
      else if (sel_stat) bus_rdata_o = DW'(stat_q);
      else if (sel_key)  bus_rdata_o = key_q;
      else if (sel_scr)  bus_rdata_o = scr_rdata;
      else begin
        for (int i = 0; i < NUM_CMP; i++)
          if (sel_cmp[i]) bus_rdata_o = cmp_val[i];
      end
    end
  end

  // Outputs
  assign irq_o    = |(stat_q[NUM_CMP-1:0] & ctrl_q[CB_CMP_EN0 +: NUM_CMP]);
  assign pwr_on_o = ctrl_q[CB_PWR_FRC] |
                    (|(stat_q[NUM_CMP-1:0] & ctrl_q[CB_PWR_RT0 +: NUM_CMP]));
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          up_we,
  input logic          key_we,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] up_q,
  input logic [DW-1:0] dn_q,
  input logic [7:0]    ctrl_q,
  input logic [2:0]    stat_q,
  input logic [DW-1:0] key_q,
  input logic          hit0,
  input logic          irq_o,
  input logic          pwr_on_o
);
  assert_tick_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_q[6] && !ctrl_q[4] && !up_we) |=> up_q == $past(up_q) + DW'(1));

  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !ctrl_q[4] && !up_we) |=> $stable(up_q));

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_we && tick && !ctrl_q[4]) |=> up_q == $past(wdata));

  assert_relatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 |=> stat_q[0]);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1:0] == 2'b00) |-> !irq_o);

  assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> pwr_on_o);

  assert_swreset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |=> (up_q == '0) && (dn_q == '1));

  assert_key_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !key_we |=> $stable(key_q));
endmodule

bind sec_rtc sec_rtc_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .tick     (tick_i),
  .up_we    (up_we),
  .key_we   (key_we),
  .wdata    (bus_wdata_i),
  .up_q     (up_cnt),
  .dn_q     (dn_cnt),
  .ctrl_q   (ctrl_q),
  .stat_q   (stat_q),
  .key_q    (key_q),
  .hit0     (hit[0]),
  .irq_o    (irq_o),
  .pwr_on_o (pwr_on_o)
);

// File: tb/sec_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, pwr;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sec_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_valid_i(valid),
    .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .pwr_on_o(pwr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd_chk("R1 up", 8'h00, 32'h0);
    rd_chk("R1 down", 8'h04, 32'hFFFF_FFFF);
    rd_chk("R1 cmp0", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R1 cmp1", 8'h0C, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl", 8'h10, 32'h0);
    rd_chk("R1 status", 8'h14, 32'h0);
    rd_chk("R1 key", 8'h18, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 pwr", {31'd0, pwr}, 32'h0);

    // R2 map, unmapped, control bit 5
    bus_wr(8'h18, 32'hB5C1_3F27);
    rd_chk("R2 key", 8'h18, 32'hB5C1_3F27);
    bus_wr(8'h10, 32'h0000_00FF);
    rd_chk("R2 ctrl bit5", 8'h10, 32'h0000_00DF);
    bus_wr(8'h10, 32'h0000_0040);
    rd_chk("R2 unmapped 1C", 8'h1C, 32'h0);
    rd_chk("R2 unmapped 40", 8'h40, 32'h0);
    rd_chk("R2 unmapped 7C", 8'h7C, 32'h0);

    // R3 sweep across the wrap point
    base = 32'hFFFF_FFEC;
    bus_wr(8'h00, base);
    bus_wr(8'h04, ~base);
    bus_wr(8'h10, 32'h0);
    for (int k = 1; k <= 40; k++) begin
      do_tick();
      rd_chk("R3 up", 8'h00, base + 32'(k));
      rd_chk("R3 down", 8'h04, ~(base + 32'(k)));
    end
    base = base + 32'd40;

    // R4 halt
    bus_wr(8'h10, 32'h0000_0040);
    for (int k = 0; k < 6; k++) begin
      do_tick();
      rd_chk("R4 up held", 8'h00, base);
      rd_chk("R4 down held", 8'h04, ~base);
    end

    // R5 write in the same cycle as a tick
    bus_wr(8'h10, 32'h0);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = 8'h00; wdata = 32'h0000_5000; tick = 1'b1;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; tick = 1'b0;
    rd_chk("R5 write wins up", 8'h00, 32'h0000_5000);
    rd_chk("R5 down ticked", 8'h04, ~base - 32'd1);

    // R6 enable gating: equality with enable clear sets nothing
    bus_wr(8'h10, 32'h0000_0040);
    bus_wr(8'h00, 32'd100);
    bus_wr(8'h04, ~32'd100);
    bus_wr(8'h08, 32'd100);
    idle(); idle();
    rd_chk("R6 no enable no status", 8'h14, 32'h0);
    // R6/R8 enabled hit
    bus_wr(8'h10, 32'h0000_0041);
    idle();
    rd_chk("R6 status0 set", 8'h14, 32'h1);
    chk("R8 irq high", {31'd0, irq}, 32'h1);
    chk("R9 pwr low unrouted", {31'd0, pwr}, 32'h0);
    // R6 relatch while equal
    bus_wr(8'h14, 32'h1);
    rd_chk("R6 relatch after clear", 8'h14, 32'h1);
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h14, 32'h1);
    rd_chk("R7 cleared once unequal", 8'h14, 32'h0);
    chk("R8 irq low", {31'd0, irq}, 32'h0);

    // R9 compare1 routed to the power-on switch
    bus_wr(8'h0C, 32'd100);
    bus_wr(8'h10, 32'h0000_004A);
    idle();
    rd_chk("R9 status1+pwr", 8'h14, 32'h6);
    chk("R9 pwr high", {31'd0, pwr}, 32'h1);
    chk("R8 irq cmp1", {31'd0, irq}, 32'h1);
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h14, 32'h0);
    rd_chk("R7 zero write no effect", 8'h14, 32'h6);
    bus_wr(8'h14, 32'h4);
    rd_chk("R7 clear bit2 only", 8'h14, 32'h2);
    chk("R9 pwr from status1", {31'd0, pwr}, 32'h1);
    bus_wr(8'h10, 32'h0000_0048);
    chk("R8 irq masked by enable", {31'd0, irq}, 32'h0);
    bus_wr(8'h14, 32'h2);
    rd_chk("R7 clear bit1", 8'h14, 32'h0);
    chk("R9 pwr low", {31'd0, pwr}, 32'h0);
    bus_wr(8'h10, 32'h0000_00C0);
    chk("R9 pwr forced", {31'd0, pwr}, 32'h1);
    chk("R8 irq not forced", {31'd0, irq}, 32'h0);

    // R10 soft reset
    bus_wr(8'h08, 32'h0000_1234);
    bus_wr(8'h10, 32'h0000_0011);
    idle();
    do_tick();
    rd_chk("R10 up held 0", 8'h00, 32'h0);
    rd_chk("R10 down held", 8'h04, 32'hFFFF_FFFF);
    rd_chk("R10 key kept", 8'h18, 32'hB5C1_3F27);
    rd_chk("R10 ctrl kept", 8'h10, 32'h0000_0011);
    rd_chk("R10 cmp0 kept", 8'h08, 32'h0000_1234);
    bus_wr(8'h10, 32'h0);
    do_tick();
    rd_chk("R10 up after release", 8'h00, 32'h1);
    rd_chk("R10 down after release", 8'h04, 32'hFFFF_FFFE);

    // R11 full scratch sweep
    for (int w = 0; w < 32; w++)
      bus_wr(8'(8'h80 + 4 * w), 32'(w) * 32'h0101_0101 ^ 32'hA5A5_5A5A);
    for (int w = 0; w < 32; w++)
      rd_chk("R11 scratch", 8'(8'h80 + 4 * w), 32'(w) * 32'h0101_0101 ^ 32'hA5A5_5A5A);
    rd_chk("R11 key untouched", 8'h18, 32'hB5C1_3F27);

    summary();
    $finish;
  end
endmodule